// File: doc/BRIEF.md
# Slot Line Payout Evaluator

This block scores one line of a three-reel slot game. It takes the symbol index that each reel stopped on and the player's bet multiplier, and returns the number of credits won. A wildcard symbol can stand in for any other symbol. Each symbol has its own three-of-a-kind pay value. Any line built only from single bars, triple bars and wildcards also pays, even when the two bar types are mixed. A line that does not win returns zero.

The caller presents the three indices and the bet with a one-cycle `in_valid` strobe. One clock later, `out_valid` pulses and `win_credits` carries the scaled payout. `win_credits` then holds that value until the next strobe. The random choice of symbols, the credit balance and coin handling are all done outside this block.

Top module: `slot_payout_eval`

## Requirements
- R1: Symbol codes are LEMON=0, CHERRY=1, BELL=2, BAR=3, TRIPLE_BAR=4, SEVEN=5, WILD=6. Reel 0 occupies `reel_sym[2:0]`, reel 1 occupies `[5:3]` and reel 2 occupies `[8:6]`.
- R2: When every non-wild reel shows the same symbol, the line pays that symbol's base times `bet`. The base values are LEMON 2, CHERRY 3, BELL 5, BAR 7, TRIPLE_BAR 9 and SEVEN 10.
- R3: Three wildcards pay 10 times `bet`.
- R4: A line whose non-wild symbols include both BAR and TRIPLE_BAR, and nothing else, pays 4 times `bet`.
- R5: A line with two different non-wild symbols that are not both bar types pays 0.
- R6: If any reel index equals 7, the payout is 0.
- R7: A `bet` of 0 gives a payout of 0. `bet` values 1 to 7 scale the base linearly.
- R8: The result appears on `win_credits`, with `out_valid` high, in the cycle after the clock edge that samples `in_valid`. `out_valid` stays high for exactly that one cycle.
- R9: When `in_valid` is low, `win_credits` keeps its previous value and the reel and bet inputs have no effect.
- R10: After reset, `out_valid` is 0 and `win_credits` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that samples the reels and the bet |
| reel_sym | input | 9 | Three 3-bit symbol indices, with reel 0 in the low bits |
| bet | input | 3 | Bet multiplier |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| win_credits | output | 7 | Payout in credits |

## Verification
Each scored result is due exactly one edge after the edge that captures `in_valid`. The bench drives inputs on a falling edge. It then reads `out_valid` and `win_credits` on the next falling edge, which falls between the capturing rising edge and the one after it. The hold checks drive new inputs without a strobe and sample one edge later, which confirms that the previous value did not change. A full sweep of all 512 index combinations at the highest bet compares every result, in that same cycle, against a count-based model in the bench.

// File: rtl/slot_pay_pkg.sv
package slot_pay_pkg;

    localparam int SYM_W = 3;
    localparam int BASE_W = 4;

    typedef enum logic [SYM_W-1:0] {
        SYM_LEMON  = 3'd0,
        SYM_CHERRY = 3'd1,
        SYM_BELL   = 3'd2,
        SYM_BAR    = 3'd3,
        SYM_TBAR   = 3'd4,
        SYM_SEVEN  = 3'd5,
        SYM_WILD   = 3'd6,
        SYM_VOID   = 3'd7
    } sym_e;

    localparam logic [BASE_W-1:0] PAY_ALL_WILD  = 4'd10;
    localparam logic [BASE_W-1:0] PAY_MIXED_BAR = 4'd4;

    function automatic logic [BASE_W-1:0] triple_pay(input logic [SYM_W-1:0] s);
        case (s)
            SYM_LEMON:  triple_pay = 4'd2;
            SYM_CHERRY: triple_pay = 4'd3;
            SYM_BELL:   triple_pay = 4'd5;
            SYM_BAR:    triple_pay = 4'd7;
            SYM_TBAR:   triple_pay = 4'd9;
            SYM_SEVEN:  triple_pay = 4'd10;
            default:    triple_pay = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/slot_reel_class.sv
module slot_reel_class
    import slot_pay_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output logic             is_wild,
    output logic             is_bar,
    output logic             is_legal
);

    always_comb begin
        is_wild  = (sym == SYM_WILD);
        is_bar   = (sym == SYM_BAR) || (sym == SYM_TBAR);
        is_legal = (sym != SYM_VOID);
    end

endmodule

// File: rtl/slot_line_judge.sv
module slot_line_judge
    import slot_pay_pkg::*;
#(
    parameter int NUM_REELS = 3
) (
    input  logic [NUM_REELS*SYM_W-1:0] syms,
    input  logic [NUM_REELS-1:0]       wild,
    input  logic [NUM_REELS-1:0]       bar,
    input  logic [NUM_REELS-1:0]       legal,
    output logic [BASE_W-1:0]          base
);

    logic             any_void;
    logic             all_wild;
    logic             have_anchor;
    logic             all_same;
    logic             bars_only;
    logic [SYM_W-1:0] anchor;

    always_comb begin
        any_void    = 1'b0;
        all_wild    = 1'b1;
        have_anchor = 1'b0;
        all_same    = 1'b1;
        bars_only   = 1'b1;
        anchor      = '0;
        for (int i = 0; i < NUM_REELS; i++) begin
            if (!legal[i]) any_void = 1'b1;
            if (!wild[i]) begin
                all_wild = 1'b0;
                if (!bar[i]) bars_only = 1'b0;
                if (!have_anchor) begin
                    anchor      = syms[i*SYM_W +: SYM_W];
                    have_anchor = 1'b1;
                end else if (syms[i*SYM_W +: SYM_W] != anchor) begin
                    all_same = 1'b0;
                end
            end
        end

        if (any_void)       base = '0;
        else if (all_wild)  base = PAY_ALL_WILD;
        else if (all_same)  base = triple_pay(anchor);
        else if (bars_only) base = PAY_MIXED_BAR;
        else                base = '0;
    end

endmodule

// File: rtl/slot_bet_scale.sv
module slot_bet_scale
    import slot_pay_pkg::*;
#(
    parameter int BET_W = 3,
    localparam int PAY_W = BASE_W + BET_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [BET_W-1:0]  bet,
    output logic [PAY_W-1:0]  credits
);

    always_comb begin
        credits = PAY_W'(base) * PAY_W'(bet);
    end

endmodule

// File: rtl/slot_payout_eval.sv
module slot_payout_eval
    import slot_pay_pkg::*;
#(
    parameter int NUM_REELS = 3,
    parameter int BET_W = 3,
    localparam int PAY_W = BASE_W + BET_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_REELS*SYM_W-1:0] reel_sym,
    input  logic [BET_W-1:0]           bet,
    output logic                       out_valid,
    output logic [PAY_W-1:0]           win_credits
);

    typedef struct packed {
        logic             vld;
        logic [PAY_W-1:0] credits;
    } res_t;

    logic [NUM_REELS-1:0] wild_v;
    logic [NUM_REELS-1:0] bar_v;
    logic [NUM_REELS-1:0] legal_v;
    logic [BASE_W-1:0]    line_base;
    logic [PAY_W-1:0]     scaled;
    res_t                 res_d, res_q;

    for (genvar g = 0; g < NUM_REELS; g++) begin : g_reel
        slot_reel_class u_class (
            .sym      (reel_sym[g*SYM_W +: SYM_W]),
            .is_wild  (wild_v[g]),
            .is_bar   (bar_v[g]),
            .is_legal (legal_v[g])
        );
    end

    slot_line_judge #(.NUM_REELS(NUM_REELS)) u_judge (
        .syms  (reel_sym),
        .wild  (wild_v),
        .bar   (bar_v),
        .legal (legal_v),
        .base  (line_base)
    );

    slot_bet_scale #(.BET_W(BET_W)) u_scale (
        .base    (line_base),
        .bet     (bet),
        .credits (scaled)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) res_d.credits = scaled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.vld;
    assign win_credits = res_q.credits;

    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(win_credits)); // R9
    AST_VOID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(&legal_v)) |=> (win_credits == '0)); // R6
    AST_ZERO_BET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bet == '0) |=> (win_credits == '0)); // R7
    AST_PAY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (win_credits <= PAY_W'(10) * PAY_W'($past(bet)))); // R2

endmodule

// File: tb/sim_slot_payout_eval.sv
`timescale 1ns/1ps
module sim_slot_payout_eval;

    localparam int NV = 22;
    // fields: [18:16] reel0, [15:13] reel1, [12:10] reel2, [9:7] bet, [6:0] expected
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 3'd0, 3'd0, 3'd1, 7'd2},   // R2 lemon
        {3'd1, 3'd1, 3'd1, 3'd2, 7'd6},   // R2 cherry
        {3'd2, 3'd2, 3'd2, 3'd3, 7'd15},  // R2 bell
        {3'd3, 3'd3, 3'd3, 3'd1, 7'd7},   // R2 bar
        {3'd4, 3'd4, 3'd4, 3'd2, 7'd18},  // R2 triple bar
        {3'd5, 3'd5, 3'd5, 3'd7, 7'd70},  // R2 seven
        {3'd6, 3'd6, 3'd6, 3'd3, 7'd30},  // R3
        {3'd6, 3'd6, 3'd0, 3'd1, 7'd2},   // R2 wild fill
        {3'd6, 3'd5, 3'd5, 3'd1, 7'd10},  // R2
        {3'd6, 3'd4, 3'd6, 3'd2, 7'd18},  // R2
        {3'd6, 3'd5, 3'd0, 3'd5, 7'd0},   // R5
        {3'd6, 3'd4, 3'd5, 3'd1, 7'd0},   // R5
        {3'd3, 3'd4, 3'd6, 3'd3, 7'd12},  // R4
        {3'd3, 3'd3, 3'd4, 3'd1, 7'd4},   // R4
        {3'd4, 3'd3, 3'd3, 3'd2, 7'd8},   // R4
        {3'd0, 3'd1, 3'd2, 3'd7, 7'd0},   // R5
        {3'd1, 3'd6, 3'd1, 3'd4, 7'd12},  // R2
        {3'd3, 3'd0, 3'd3, 3'd1, 7'd0},   // R5
        {3'd7, 3'd0, 3'd0, 3'd5, 7'd0},   // R6
        {3'd6, 3'd6, 3'd7, 3'd1, 7'd0},   // R6
        {3'd5, 3'd5, 3'd5, 3'd0, 7'd0},   // R7
        {3'd2, 3'd6, 3'd6, 3'd6, 7'd30}   // R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] reel_sym = '0;
    logic [2:0] bet = '0;
    logic       out_valid;
    logic [6:0] win_credits;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slot_payout_eval u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .reel_sym    (reel_sym),
        .bet         (bet),
        .out_valid   (out_valid),
        .win_credits (win_credits)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int a, input int b, input int c, input int k);
        int cnt[8];
        int nw, kinds, only_sym;
        bit barish;
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        cnt[a]++; cnt[b]++; cnt[c]++;
        if (cnt[7] != 0) return 0;
        nw = cnt[6];
        if (nw == 3) return 10 * k;
        kinds = 0; only_sym = 0;
        for (int i = 0; i < 6; i++) if (cnt[i] != 0) begin kinds++; only_sym = i; end
        if (kinds == 1) begin
            case (only_sym)
                0: return 2 * k;
                1: return 3 * k;
                2: return 5 * k;
                3: return 7 * k;
                4: return 9 * k;
                default: return 10 * k;
            endcase
        end
        barish = (cnt[3] + cnt[4] + nw == 3);
        return barish ? 4 * k : 0;
    endfunction

    task automatic score(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                         input logic [2:0] k);
        @(negedge clk);
        reel_sym = {c, b, a};
        bet      = k;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 out_valid", int'(out_valid), 0);
        check("R10 win_credits", int'(win_credits), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            score(VEC[v][18:16], VEC[v][15:13], VEC[v][12:10], VEC[v][9:7]);
            check("R1/R2-R7 table", int'(win_credits), int'(VEC[v][6:0]));
            check("R8 pulse", int'(out_valid), 1);
        end

        // R8 / R9: nonzero result then idle with changing inputs
        score(3'd5, 3'd5, 3'd5, 3'd7);
        check("R8 due", int'(win_credits), 70);
        reel_sym = {3'd0, 3'd0, 3'd0};
        bet = 3'd1;
        @(negedge clk);
        check("R8 one-cycle", int'(out_valid), 0);
        check("R9 hold", int'(win_credits), 70);
        reel_sym = {3'd1, 3'd2, 3'd7};
        @(negedge clk);
        check("R9 ignored", int'(win_credits), 70);

        // full sweep at the top bet
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 8; c++) begin
                    score(3'(a), 3'(b), 3'(c), 3'd7);
                    check("R2-R6 sweep", int'(win_credits), model(a, b, c, 7));
                end

        // R10 reset mid-run clears the result
        score(3'd6, 3'd6, 3'd6, 3'd7);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears", int'(win_credits), 0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule